// File: doc/BRIEF.md
# Line-Aliasing Memory Request Tracker

This block sits between a requester and a cache controller. It keeps a record of which cache lines have a memory request in flight. Each request comes with a type code and a byte address. The tracker reduces the address to its cache line and sorts the type into one of two classes: read-class or write-class. It then checks the line against both pending tables.

A request is turned away as aliased when any entry already pending for the same line conflicts with it. This includes an entry in the table of the opposite class. A request is turned away as full when the tracker has no room. Otherwise the request is recorded in the table of its class, and its status is ready.

Completion inputs retire a pending line from the table the completion names. Four counters record alias events, one for each pairing of the new request's class with the class of the entry that blocked it. A running outstanding count is also given.

Top module: `lat_tracker`

## Requirements
- R1: The line address is the byte address with its low log2(LINE_BYTES) bits cleared (6 bits by default). Two addresses in the same line are treated as the same line.
- R2: The type codes 2 to 9 are write-class. These are store (2), read-modify-write read (3), read-modify-write write (4), load-linked (5), store-conditional (6), locked read (7), locked write (8) and flush (9). Every other code is read-class, including load (0) and instruction fetch (1).
- R3: When the outstanding count is at or above MAX_OUT, a request gets status full (2'b10) before any lookup. No table and no counter changes.
- R4: A write-class request whose line is pending in the read table gets status aliased (2'b01), and the store-on-load counter increments.
- R5: A write-class request whose line is pending in the write table gets status aliased, and the store-on-store counter increments.
- R6: A read-class request whose line is pending in the write table gets status aliased, and the load-on-store counter increments. This check comes before the read table is checked.
- R7: A read-class request whose line is pending in the read table gets status aliased, and the load-on-load counter increments.
- R8: A request with no conflict is entered into its class table with status ready (2'b00), and the outstanding count rises by one. The count always equals the total occupancy of the two tables.
- R9: A completion with `cmp_wr` set removes a matching line from the write table. With `cmp_wr` clear, it removes a matching line from the read table. A removal lowers the count by one. A completion that finds no matching line in the named table has no effect.
- R10: `rsp_valid` and `rsp_status` appear on the clock edge that samples `req_valid`, so they can be read one cycle after the request. The status is always one of 00, 01 or 10.
- R11: A request with no conflict whose class table has no free slot gets status full, even when the count is below MAX_OUT.
- R12: Reset clears both tables, the outstanding count, all four counters and `rsp_valid`.
- R13: A request and a completion in the same cycle both take effect. The request is judged against the tables as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_type | input | 4 | Request type code |
| req_addr | input | ADDR_W | Request byte address |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_wr | input | 1 | Completion targets the write table (1) or the read table (0) |
| cmp_addr | input | ADDR_W | Byte address of the completed line |
| rsp_valid | output | 1 | Status valid, one cycle after the request |
| rsp_status | output | 2 | 00 ready, 01 aliased, 10 full |
| outstanding | output | CNT_W | Number of lines pending in both tables |
| cnt_st_on_ld | output | CTR_W | Write-class requests blocked by a pending read |
| cnt_st_on_st | output | CTR_W | Write-class requests blocked by a pending write |
| cnt_ld_on_st | output | CTR_W | Read-class requests blocked by a pending write |
| cnt_ld_on_ld | output | CTR_W | Read-class requests blocked by a pending read |

## Verification
Every result is registered at the single clock edge that samples the request. The status, the outstanding count, the table contents and the alias counters are therefore all due one cycle after the stimulus. A completion's effect on the count is due at the same edge. The bench drives inputs at the falling edge and samples one nanosecond after the following rising edge. Every per-step check, and every check of a counter total, is read at that single point. Corner cases are placed at that same edge as well: a same-cycle completion and request, full-before-lookup, and a class table that has no free slot.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'b00,
    ST_ALIAS = 2'b01,
    ST_FULL  = 2'b10
  } lat_status_e;

  typedef enum logic [3:0] {
    RT_LOAD    = 4'd0,
    RT_IFETCH  = 4'd1,
    RT_STORE   = 4'd2,
    RT_RMW_RD  = 4'd3,
    RT_RMW_WR  = 4'd4,
    RT_LINK_LD = 4'd5,
    RT_COND_ST = 4'd6,
    RT_LOCK_RD = 4'd7,
    RT_LOCK_WR = 4'd8,
    RT_FLUSH   = 4'd9
  } lat_type_e;
endpackage

// File: rtl/lat_classify.sv
module lat_classify (
  input  logic [3:0] req_type,
  output logic       is_wr
);
  import lat_pkg::*;

  // R2: write-class codes; everything else is read-class
  always_comb begin
    case (req_type)
      RT_STORE, RT_RMW_RD, RT_RMW_WR, RT_LINK_LD,
      RT_COND_ST, RT_LOCK_RD, RT_LOCK_WR, RT_FLUSH: is_wr = 1'b1;
      default:                                      is_wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/lat_cam.sv
module lat_cam #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic              has_free,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic              rm_en,
  input  logic [LINE_W-1:0] rm_line,
  output logic              rm_hit,
  output logic [OCC_W-1:0]  occ
);
  logic [DEPTH-1:0]  vld;
  logic [LINE_W-1:0] tag [DEPTH];
  logic [DEPTH-1:0]  look_m;
  logic [DEPTH-1:0]  rm_m;
  logic [IDX_W-1:0]  free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign look_m[g] = vld[g] && (tag[g] == look_line);
    assign rm_m[g]   = vld[g] && (tag[g] == rm_line);
  end

  assign look_hit = |look_m;
  assign rm_hit   = rm_en && (|rm_m);
  assign has_free = ~&vld;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++)
      occ = occ + OCC_W'(vld[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rm_en && rm_m[i]) vld[i] <= 1'b0;
        if (ins_en && (free_idx == IDX_W'(i))) begin
          vld[i] <= 1'b1;
          tag[i] <= ins_line;
        end
      end
    end
  end

  // R11
  ins_room_chk: assert property (@(posedge clk) disable iff (rst) ins_en |-> has_free);
  // R8
  one_entry_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(look_m));
endmodule

// File: rtl/lat_tracker.sv
module lat_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int CTR_W      = 16,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFS_W,
  localparam int CNT_W     = $clog2(MAX_OUT + 1),
  localparam int RD_OCC_W  = $clog2(RD_DEPTH + 1),
  localparam int WR_OCC_W  = $clog2(WR_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cmp_valid,
  input  logic              cmp_wr,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [CNT_W-1:0]  outstanding,
  output logic [CTR_W-1:0]  cnt_st_on_ld,
  output logic [CTR_W-1:0]  cnt_st_on_st,
  output logic [CTR_W-1:0]  cnt_ld_on_st,
  output logic [CTR_W-1:0]  cnt_ld_on_ld
);
  import lat_pkg::*;

  // R1: line address drops the offset bits
  logic [LINE_W-1:0] req_line, cmp_line;
  logic              unused_ofs;
  assign req_line   = req_addr[ADDR_W-1:OFS_W];
  assign cmp_line   = cmp_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^{req_addr[OFS_W-1:0], cmp_addr[OFS_W-1:0]};

  logic is_wr;
  lat_classify u_cls (.req_type(req_type), .is_wr(is_wr));

  logic rd_hit, rd_free, rd_rm, ins_rd;
  logic wr_hit, wr_free, wr_rm, ins_wr;
  logic [RD_OCC_W-1:0] rd_occ;
  logic [WR_OCC_W-1:0] wr_occ;

  lat_cam #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W)) u_rd_tab (
    .clk(clk), .rst(rst), .look_line(req_line), .look_hit(rd_hit), .has_free(rd_free),
    .ins_en(ins_rd), .ins_line(req_line), .rm_en(cmp_valid && !cmp_wr),
    .rm_line(cmp_line), .rm_hit(rd_rm), .occ(rd_occ));

  lat_cam #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W)) u_wr_tab (
    .clk(clk), .rst(rst), .look_line(req_line), .look_hit(wr_hit), .has_free(wr_free),
    .ins_en(ins_wr), .ins_line(req_line), .rm_en(cmp_valid && cmp_wr),
    .rm_line(cmp_line), .rm_hit(wr_rm), .occ(wr_occ));

  lat_status_e nxt_status;
  logic        at_max;
  logic        ev_sl, ev_ss, ev_ls, ev_ll;
  assign at_max = (int'(outstanding) >= MAX_OUT);

  // R3..R7, R11: decision order is full, cross-class alias, same-class alias, room
  always_comb begin
    nxt_status = ST_READY;
    ins_rd = 1'b0; ins_wr = 1'b0;
    ev_sl = 1'b0; ev_ss = 1'b0; ev_ls = 1'b0; ev_ll = 1'b0;
    if (req_valid) begin
      if (at_max) begin
        nxt_status = ST_FULL;
      end else if (is_wr) begin
        if (rd_hit)        begin nxt_status = ST_ALIAS; ev_sl = 1'b1; end
        else if (wr_hit)   begin nxt_status = ST_ALIAS; ev_ss = 1'b1; end
        else if (!wr_free) nxt_status = ST_FULL;
        else               ins_wr = 1'b1;
      end else begin
        if (wr_hit)        begin nxt_status = ST_ALIAS; ev_ls = 1'b1; end
        else if (rd_hit)   begin nxt_status = ST_ALIAS; ev_ll = 1'b1; end
        else if (!rd_free) nxt_status = ST_FULL;
        else               ins_rd = 1'b1;
      end
    end
  end

  logic ins_any, rm_any;
  assign ins_any = ins_rd || ins_wr;
  assign rm_any  = rd_rm || wr_rm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= ST_READY;
      outstanding  <= '0;
      cnt_st_on_ld <= '0;
      cnt_st_on_st <= '0;
      cnt_ld_on_st <= '0;
      cnt_ld_on_ld <= '0;
    end else begin
      rsp_valid   <= req_valid;
      if (req_valid) rsp_status <= nxt_status;
      outstanding <= outstanding + CNT_W'(ins_any) - CNT_W'(rm_any);
      if (ev_sl) cnt_st_on_ld <= cnt_st_on_ld + 1'b1;
      if (ev_ss) cnt_st_on_st <= cnt_st_on_st + 1'b1;
      if (ev_ls) cnt_ld_on_st <= cnt_ld_on_st + 1'b1;
      if (ev_ll) cnt_ld_on_ld <= cnt_ld_on_ld + 1'b1;
    end
  end

  // R8
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    int'(outstanding) == int'(rd_occ) + int'(wr_occ));
  // R3
  count_max_chk: assert property (@(posedge clk) disable iff (rst)
    int'(outstanding) <= MAX_OUT);
  // R3
  full_first_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && at_max) |=> (rsp_status == ST_FULL) && $stable(cnt_st_on_ld)
      && $stable(cnt_st_on_st) && $stable(cnt_ld_on_st) && $stable(cnt_ld_on_ld));
  // R4
  excl_line_chk: assert property (@(posedge clk) disable iff (rst) !(rd_hit && wr_hit));
  // R10
  rsp_rise_chk: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid);
  // R10
  status_code_chk: assert property (@(posedge clk) disable iff (rst) rsp_status != 2'b11);
endmodule

// File: tb/test_lat_tracker.sv
module test_lat_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic        cmp_valid = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [31:0] cmp_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [2:0]  outstanding;
  logic [15:0] c_sl, c_ss, c_ls, c_ll;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  lat_tracker i_lat_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .cmp_valid(cmp_valid), .cmp_wr(cmp_wr), .cmp_addr(cmp_addr),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .outstanding(outstanding),
    .cnt_st_on_ld(c_sl), .cnt_st_on_st(c_ss), .cnt_ld_on_st(c_ls), .cnt_ld_on_ld(c_ll));

  typedef struct packed {
    logic        rv;
    logic [3:0]  ty;
    logic [15:0] ad;
    logic        cv;
    logic        cw;
    logic [15:0] ca;
    logic [1:0]  st;
    logic [3:0]  cnt;
  } vec_t;

  // MAX_OUT 6, 4 entries per table, 64-byte lines
  localparam vec_t VEC [20] = '{
    '{1'b1, 4'd0, 16'h1000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd1}, // R8 load ready
    '{1'b1, 4'd0, 16'h1010, 1'b0, 1'b0, 16'h0000, 2'b01, 4'd1}, // R1 R7
    '{1'b1, 4'd2, 16'h103F, 1'b0, 1'b0, 16'h0000, 2'b01, 4'd1}, // R4
    '{1'b1, 4'd2, 16'h2000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd2}, // R8
    '{1'b1, 4'd9, 16'h2004, 1'b0, 1'b0, 16'h0000, 2'b01, 4'd2}, // R5 R2 flush
    '{1'b1, 4'd1, 16'h2020, 1'b0, 1'b0, 16'h0000, 2'b01, 4'd2}, // R6 fetch
    '{1'b1, 4'd5, 16'h3000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd3}, // R2 linked load
    '{1'b1, 4'd1, 16'h3000, 1'b0, 1'b0, 16'h0000, 2'b01, 4'd3}, // R6
    '{1'b1, 4'd0, 16'h1040, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd4}, // R1 next line
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 16'h1000, 2'b00, 4'd3}, // R9 remove read
    '{1'b1, 4'd2, 16'h1000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd4}, // R9 line free again
    '{1'b1, 4'd6, 16'h4000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd5}, // R2
    '{1'b1, 4'd8, 16'h5000, 1'b0, 1'b0, 16'h0000, 2'b10, 4'd5}, // R11 write table full
    '{1'b1, 4'd0, 16'h6000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd6}, // R8
    '{1'b1, 4'd0, 16'h7000, 1'b0, 1'b0, 16'h0000, 2'b10, 4'd6}, // R3
    '{1'b1, 4'd2, 16'h6000, 1'b0, 1'b0, 16'h0000, 2'b10, 4'd6}, // R3 before lookup
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b1, 16'h8000, 2'b00, 4'd6}, // R9 absent line
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b1, 16'h2000, 2'b00, 4'd5}, // R9 remove write
    '{1'b1, 4'd0, 16'h2000, 1'b0, 1'b0, 16'h0000, 2'b00, 4'd6}, // R8
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b1, 16'h1040, 2'b00, 4'd6}  // R9 wrong table
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [3:0] ty, input logic [31:0] ad,
                      input logic cv, input logic cw, input logic [31:0] ca);
    @(negedge clk);
    req_valid = rv; req_type = ty; req_addr = ad;
    cmp_valid = cv; cmp_wr = cw; cmp_addr = ca;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R12 reset count", 32'(outstanding), 0);
    chk("R12 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R12 reset counters", 32'(c_sl | c_ss | c_ls | c_ll), 0);

    for (int i = 0; i < 20; i++) begin
      step(VEC[i].rv, VEC[i].ty, {16'h0, VEC[i].ad}, VEC[i].cv, VEC[i].cw, {16'h0, VEC[i].ca});
      chk($sformatf("R10 rsp_valid v%0d", i), 32'(rsp_valid), 32'(VEC[i].rv));
      if (VEC[i].rv) chk($sformatf("R10 status v%0d", i), 32'(rsp_status), 32'(VEC[i].st));
      chk($sformatf("R8 count v%0d", i), 32'(outstanding), 32'(VEC[i].cnt));
    end
    chk("R4 st_on_ld", 32'(c_sl), 1);
    chk("R5 st_on_st", 32'(c_ss), 1);
    chk("R6 ld_on_st", 32'(c_ls), 2);
    chk("R7 ld_on_ld", 32'(c_ll), 1);

    // R12 reset mid-run
    @(negedge clk);
    req_valid = 1'b0; cmp_valid = 1'b0; rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R12 count cleared", 32'(outstanding), 0);
    chk("R12 counters cleared", 32'(c_sl | c_ss | c_ls | c_ll), 0);
    // R12: tables empty, an old line is accepted again
    step(1'b1, 4'd2, 32'h2000, 1'b0, 1'b0, 32'h0);
    chk("R12 table cleared", 32'(rsp_status), 0);
    step(1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 32'h2000);
    chk("R9 cleanup", 32'(outstanding), 0);

    // R2: remaining write-class codes against a pending read; code 10 is read-class
    step(1'b1, 4'd0, 32'h0100, 1'b0, 1'b0, 32'h0);
    chk("R8 ready", 32'(rsp_status), 0);
    step(1'b1, 4'd3, 32'h0108, 1'b0, 1'b0, 32'h0);
    chk("R2 code3 alias", 32'(rsp_status), 1);
    step(1'b1, 4'd4, 32'h0110, 1'b0, 1'b0, 32'h0);
    chk("R2 code4 alias", 32'(rsp_status), 1);
    step(1'b1, 4'd7, 32'h0120, 1'b0, 1'b0, 32'h0);
    chk("R2 code7 alias", 32'(rsp_status), 1);
    chk("R2 st_on_ld total", 32'(c_sl), 3);
    step(1'b1, 4'd10, 32'h0130, 1'b0, 1'b0, 32'h0);
    chk("R2 code10 read-class", 32'(c_ll), 1);

    // R13: completion and conflicting request in one cycle
    step(1'b1, 4'd2, 32'h0100, 1'b1, 1'b0, 32'h0100);
    chk("R13 pre-edge alias", 32'(rsp_status), 1);
    chk("R13 removal applied", 32'(outstanding), 0);
    chk("R13 st_on_ld", 32'(c_sl), 4);
    step(1'b1, 4'd2, 32'h0100, 1'b0, 1'b0, 32'h0);
    chk("R13 line free after", 32'(rsp_status), 0);
    chk("R13 count", 32'(outstanding), 1);
    step(1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R10 idle", 32'(rsp_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule